// File: doc/BRIEF.md
# DRAM Refresh and Initialization Sequencer

This block sits on the host side of an asynchronous DRAM and keeps its contents alive. After reset it holds every strobe inactive for a power-up pause. It then runs a fixed burst of wake-up cycles on its own and only after that declares the memory ready. From then on an interval timer adds one owed refresh at a time to a pending counter. The block raises a request toward the memory access controller, and each grant it receives produces one CAS-before-RAS refresh cycle on the strobe pins. No address is needed, because the memory steps through its rows from an internal counter.

All timing is entered in nanoseconds together with the clock period and converted to clock counts when the block is built. Minimum pulse widths are rounded up. The refresh interval, which is a maximum, is rounded down. A small number of refreshes may be postponed while the access controller finishes a page burst. If one more interval expires with the pending counter already full, the refresh deadline counts as missed: an error flag is raised, readiness is withdrawn and the whole wake-up burst runs again.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is held and during the power-up pause, `rasN`, both bits of `casN` and `weN` are 1, `refBusy` is 1, and `initDone`, `refReq` and `refErr` are 0.
- R2: The first falling edge of `rasN` is sampled exactly PAUSE_CYC + SETUP_CYC clock edges after the first edge with reset released.
- R3: After the pause, exactly WAKE_CYCLES refresh cycles run back to back without any grant. `initDone` rises PAUSE_CYC + WAKE_CYCLES*(SETUP_CYC+RASLO_CYC+PRECHG_CYC) edges after reset release.
- R4: Every cycle is CAS-before-RAS. Both `casN` bits go to 0 one edge after the cycle starts and stay 0 for SETUP_CYC cycles before `rasN` falls. `weN` stays 1 throughout.
- R5: `rasN` stays 0 for exactly RASLO_CYC cycles, and both `casN` bits return to 1 on the same edge that `rasN` returns to 1.
- R6: After each cycle, all strobes stay high for PRECHG_CYC cycles, and `refBusy` stays 1 through that precharge.
- R7: Once `initDone` is 1, one refresh becomes owed every REFRESH_CYC edges. The first `refReq` appears REFRESH_CYC edges after `initDone` rises. `refReq` is only ever 1 while `initDone` is 1 and `refBusy` is 0.
- R8: A `refGrant` sampled while `refReq` is 1 starts a cycle on the next edge. From that edge `refBusy` is 1 and `refReq` is 0, and `refBusy` returns to 0 SETUP_CYC+RASLO_CYC+PRECHG_CYC+1 edges after the grant edge.
- R9: Up to MAX_PENDING refreshes are held. A grant held high serves every owed refresh, one cycle each, and then `refReq` returns to 0.
- R10: A timer expiry that finds MAX_PENDING refreshes owed and none starting sets `refErr`, which stays 1 until reset. On that same edge it clears `initDone` and the owed count, and WAKE_CYCLES wake-up cycles then run again before `initDone` returns.
- R11: `refGrant` has no effect during the pause, during wake-up, or when nothing is owed: the strobes stay 1.
- R12: The clock counts are PAUSE_CYC = ceil(PAUSE_NS/period), SETUP_CYC = ceil(CAS_SETUP_NS/period), RASLO_CYC = ceil(RAS_LOW_NS/period) and PRECHG_CYC = ceil(PRECHG_NS/period). REFRESH_CYC = floor(REFRESH_NS/period), with a minimum of 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| refGrant | input | 1 | Access controller lets a refresh start |
| refReq | output | 1 | At least one refresh is owed and the sequencer is idle |
| refBusy | output | 1 | Sequencer owns the strobes (pause, wake-up or refresh incl. precharge) |
| initDone | output | 1 | Pause and wake-up complete; normal accesses allowed |
| refErr | output | 1 | Sticky: refresh deadline was missed |
| rasN | output | 1 | Row strobe to the memory, active low |
| casN | output | 2 | Both byte column strobes, active low |
| weN | output | 1 | Write enable to the memory, held high |

## Verification
The checks assume that the access controller raises `refGrant` only as a reply to `refReq`, and that it does not drive the strobes itself while `refBusy` is 1. Under that assumption, every falling edge of `casN` after initialization can be traced back to a grant one edge earlier. The stimulus respects this. It holds grant high during the pause and the wake-up burst and with nothing owed, to show that grant is ignored there. Otherwise it raises grant only while a request is visible, either as a single-cycle pulse or held across a drain of several owed refreshes. Each wait in the stimulus is timed against the known interval ticks so that no tick lands in the middle of a measured window.

// File: rtl/dram_refresh_pkg.sv
`timescale 1ns/1ps
package dram_refresh_pkg;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_IDLE,
    ST_SETUP,
    ST_RASLO,
    ST_PRECHG
  } seqState_t;

  typedef enum logic [1:0] {
    PH_SETUP,
    PH_RASLO,
    PH_PRECHG
  } phaseSel_t;

  typedef struct packed {
    logic      loadPhase;
    phaseSel_t phaseSel;
    logic      takeRefresh;
    logic      loadWake;
    logic      decWake;
  } dpStrobe_t;

  function automatic int unsigned cycCeil(input int unsigned ns, input int unsigned periodPs);
    return (ns * 1000 + periodPs - 1) / periodPs;
  endfunction

  function automatic int unsigned cycFloor(input int unsigned ns, input int unsigned periodPs);
    return (ns * 1000) / periodPs;
  endfunction

  function automatic int unsigned maxOf(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dram_refresh_dp.sv
`timescale 1ns/1ps
module dram_refresh_dp
  import dram_refresh_pkg::*;
#(
  parameter int unsigned PAUSE_CYC   = 25000,
  parameter int unsigned SETUP_CYC   = 1,
  parameter int unsigned RASLO_CYC   = 5,
  parameter int unsigned PRECHG_CYC  = 4,
  parameter int unsigned REFRESH_CYC = 1953,
  parameter int unsigned WAKE_CYCLES = 8,
  parameter int unsigned MAX_PENDING = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  dpStrobe_t  strobe,
  input  logic       initDone,
  output logic       phaseDone,
  output logic       wakeLast,
  output logic       pendNz,
  output logic       overflow
);

  localparam int unsigned MAX_PH = maxOf(maxOf(PAUSE_CYC, SETUP_CYC), maxOf(RASLO_CYC, PRECHG_CYC));
  localparam int unsigned PH_W   = $clog2(MAX_PH + 1);
  localparam int unsigned WK_W   = $clog2(WAKE_CYCLES + 1);
  localparam int unsigned TM_W   = $clog2(REFRESH_CYC);
  localparam int unsigned PD_W   = $clog2(MAX_PENDING + 1);

  logic [PH_W-1:0] phaseCnt;
  logic [PH_W-1:0] phaseLen;
  logic [WK_W-1:0] wakeCnt;
  logic [TM_W-1:0] timerCnt;
  logic [PD_W-1:0] pendCnt;
  logic            tick;

  // duration of the phase being entered, minus one
  always_comb begin
    case (strobe.phaseSel)
      PH_SETUP:  phaseLen = PH_W'(SETUP_CYC - 1);
      PH_RASLO:  phaseLen = PH_W'(RASLO_CYC - 1);
      default:   phaseLen = PH_W'(PRECHG_CYC - 1);
    endcase
  end

  // shared down counter: power-up pause first, then each strobe phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 phaseCnt <= PH_W'(PAUSE_CYC - 1);
    else if (strobe.loadPhase)  phaseCnt <= phaseLen;
    else if (phaseCnt != '0)    phaseCnt <= phaseCnt - 1'b1;
  end
  assign phaseDone = (phaseCnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                wakeCnt <= '0;
    else if (strobe.loadWake)  wakeCnt <= WK_W'(WAKE_CYCLES);
    else if (strobe.decWake)   wakeCnt <= wakeCnt - 1'b1;
  end
  assign wakeLast = (wakeCnt == WK_W'(1));

  // interval timer runs only once the memory is ready
  assign tick = initDone && (timerCnt == TM_W'(REFRESH_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         timerCnt <= '0;
    else if (!initDone) timerCnt <= '0;
    else if (tick)      timerCnt <= '0;
    else                timerCnt <= timerCnt + 1'b1;
  end

  assign overflow = tick && (pendCnt == PD_W'(MAX_PENDING)) && !strobe.takeRefresh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   pendCnt <= '0;
    else if (!initDone || overflow) pendCnt <= '0;
    else begin
      case ({tick, strobe.takeRefresh})
        2'b10:   pendCnt <= pendCnt + 1'b1;
        2'b01:   pendCnt <= pendCnt - 1'b1;
        default: pendCnt <= pendCnt;
      endcase
    end
  end
  assign pendNz = (pendCnt != '0);

endmodule

// File: rtl/dram_refresh_ctrl.sv
`timescale 1ns/1ps
module dram_refresh_ctrl
  import dram_refresh_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       refGrant,
  input  logic       phaseDone,
  input  logic       wakeLast,
  input  logic       pendNz,
  input  logic       overflow,
  output dpStrobe_t  strobe,
  output logic       initDone,
  output logic       refErr,
  output logic       refReq,
  output logic       refBusy,
  output logic       rasN,
  output logic       casLow
);

  seqState_t state, nextState;
  logic      waking, reWake;
  logic      startWake, finishWake;

  always_comb begin
    nextState  = state;
    strobe     = '0;
    startWake  = 1'b0;
    finishWake = 1'b0;
    case (state)
      ST_PAUSE: begin
        if (phaseDone) begin
          nextState       = ST_SETUP;
          strobe.loadPhase = 1'b1;
          strobe.phaseSel  = PH_SETUP;
          strobe.loadWake  = 1'b1;
          startWake        = 1'b1;
        end
      end
      ST_IDLE: begin
        if (reWake) begin
          nextState        = ST_SETUP;
          strobe.loadPhase = 1'b1;
          strobe.phaseSel  = PH_SETUP;
          strobe.loadWake  = 1'b1;
          startWake        = 1'b1;
        end else if (initDone && pendNz && refGrant) begin
          nextState          = ST_SETUP;
          strobe.loadPhase   = 1'b1;
          strobe.phaseSel    = PH_SETUP;
          strobe.takeRefresh = 1'b1;
        end
      end
      ST_SETUP: begin
        if (phaseDone) begin
          nextState        = ST_RASLO;
          strobe.loadPhase = 1'b1;
          strobe.phaseSel  = PH_RASLO;
        end
      end
      ST_RASLO: begin
        if (phaseDone) begin
          nextState        = ST_PRECHG;
          strobe.loadPhase = 1'b1;
          strobe.phaseSel  = PH_PRECHG;
        end
      end
      ST_PRECHG: begin
        if (phaseDone) begin
          if (waking && !wakeLast) begin
            nextState        = ST_SETUP;
            strobe.loadPhase = 1'b1;
            strobe.phaseSel  = PH_SETUP;
            strobe.decWake   = 1'b1;
          end else begin
            nextState  = ST_IDLE;
            finishWake = waking;
          end
        end
      end
      default: nextState = ST_PAUSE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_PAUSE;
      waking   <= 1'b0;
      reWake   <= 1'b0;
      initDone <= 1'b0;
      refErr   <= 1'b0;
    end else begin
      state <= nextState;
      if (startWake)       waking <= 1'b1;
      else if (finishWake) waking <= 1'b0;
      if (overflow)        reWake <= 1'b1;
      else if (startWake)  reWake <= 1'b0;
      if (overflow)        initDone <= 1'b0;
      else if (finishWake) initDone <= 1'b1;
      if (overflow)        refErr <= 1'b1;
    end
  end

  assign rasN    = (state != ST_RASLO);
  assign casLow  = (state == ST_SETUP) || (state == ST_RASLO);
  assign refBusy = (state != ST_IDLE);
  assign refReq  = (state == ST_IDLE) && initDone && pendNz && !reWake;

endmodule

// File: rtl/dram_refresh_seq.sv
`timescale 1ns/1ps
module dram_refresh_seq
  import dram_refresh_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 8000,
  parameter int unsigned PAUSE_NS      = 200000,
  parameter int unsigned REFRESH_NS    = 15625,
  parameter int unsigned CAS_SETUP_NS  = 8,
  parameter int unsigned RAS_LOW_NS    = 35,
  parameter int unsigned PRECHG_NS     = 25,
  parameter int unsigned WAKE_CYCLES   = 8,
  parameter int unsigned MAX_PENDING   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       refGrant,
  output logic       refReq,
  output logic       refBusy,
  output logic       initDone,
  output logic       refErr,
  output logic       rasN,
  output logic [1:0] casN,
  output logic       weN
);

  localparam int unsigned PAUSE_CYC   = cycCeil(PAUSE_NS, CLK_PERIOD_PS);
  localparam int unsigned SETUP_CYC   = cycCeil(CAS_SETUP_NS, CLK_PERIOD_PS);
  localparam int unsigned RASLO_CYC   = cycCeil(RAS_LOW_NS, CLK_PERIOD_PS);
  localparam int unsigned PRECHG_CYC  = cycCeil(PRECHG_NS, CLK_PERIOD_PS);
  localparam int unsigned REFRESH_RAW = cycFloor(REFRESH_NS, CLK_PERIOD_PS);
  localparam int unsigned REFRESH_CYC = (REFRESH_RAW < 2) ? 2 : REFRESH_RAW;

  dpStrobe_t strobe;
  logic      phaseDone, wakeLast, pendNz, overflow, casLow;

  dram_refresh_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .refGrant  (refGrant),
    .phaseDone (phaseDone),
    .wakeLast  (wakeLast),
    .pendNz    (pendNz),
    .overflow  (overflow),
    .strobe    (strobe),
    .initDone  (initDone),
    .refErr    (refErr),
    .refReq    (refReq),
    .refBusy   (refBusy),
    .rasN      (rasN),
    .casLow    (casLow)
  );

  dram_refresh_dp #(
    .PAUSE_CYC   (PAUSE_CYC),
    .SETUP_CYC   (SETUP_CYC),
    .RASLO_CYC   (RASLO_CYC),
    .PRECHG_CYC  (PRECHG_CYC),
    .REFRESH_CYC (REFRESH_CYC),
    .WAKE_CYCLES (WAKE_CYCLES),
    .MAX_PENDING (MAX_PENDING)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .initDone  (initDone),
    .phaseDone (phaseDone),
    .wakeLast  (wakeLast),
    .pendNz    (pendNz),
    .overflow  (overflow)
  );

  assign casN = {2{~casLow}};
  assign weN  = 1'b1;

endmodule

// File: rtl/dram_refresh_chk.sv
`timescale 1ns/1ps
module dram_refresh_chk #(
  parameter int unsigned RASLO_CYC  = 5,
  parameter int unsigned PRECHG_CYC = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       refGrant,
  input logic       refReq,
  input logic       refBusy,
  input logic       initDone,
  input logic       refErr,
  input logic       rasN,
  input logic [1:0] casN,
  input logic       weN
);

  logic [15:0] lowRun, highRun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lowRun  <= '0;
      highRun <= '0;
    end else begin
      if (!rasN) lowRun <= (lowRun == 16'hFFFF) ? lowRun : lowRun + 1'b1;
      else       lowRun <= '0;
      if (rasN)  highRun <= (highRun == 16'hFFFF) ? highRun : highRun + 1'b1;
      else       highRun <= '0;
    end
  end

  assert_cas_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rasN) |-> ($past(casN) == 2'b00) && (casN == 2'b00) && weN);

  assert_ras_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rasN) |-> (lowRun >= 16'(RASLO_CYC)) && (casN == 2'b11));

  assert_precharge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rasN) |-> highRun >= 16'(PRECHG_CYC));

  assert_req_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    refReq |-> initDone && !refBusy);

  assert_busy_cover_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rasN || casN != 2'b11) |-> refBusy);

  assert_grant_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(casN[0]) && $past(initDone)) |-> $past(refGrant) && $past(refReq));

  assert_err_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(refErr) |-> !initDone);

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    refErr |=> refErr);

endmodule

bind dram_refresh_seq dram_refresh_chk #(
  .RASLO_CYC  (RASLO_CYC),
  .PRECHG_CYC (PRECHG_CYC)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .refGrant (refGrant),
  .refReq   (refReq),
  .refBusy  (refBusy),
  .initDone (initDone),
  .refErr   (refErr),
  .rasN     (rasN),
  .casN     (casN),
  .weN      (weN)
);

// File: tb/dram_refresh_seq_bench.sv
`timescale 1ns/1ps
module dram_refresh_seq_bench;

  localparam int PERIOD_PS = 8000;
  localparam int P_CYC  = (200000 * 1000 + PERIOD_PS - 1) / PERIOD_PS;
  localparam int S_CYC  = (8 * 1000 + PERIOD_PS - 1) / PERIOD_PS;
  localparam int RL_CYC = (35 * 1000 + PERIOD_PS - 1) / PERIOD_PS;
  localparam int PR_CYC = (25 * 1000 + PERIOD_PS - 1) / PERIOD_PS;
  localparam int RF_CYC = (15625 * 1000) / PERIOD_PS;
  localparam int W_CYC  = 8;
  localparam int L_CYC  = S_CYC + RL_CYC + PR_CYC;

  typedef struct packed {
    logic [7:0] off;
    logic       ras;
    logic       casLow;
    logic       busy;
    logic       req;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{off: 8'(1),                      ras: 1'b1, casLow: 1'b1, busy: 1'b1, req: 1'b0},
    '{off: 8'(S_CYC),                  ras: 1'b1, casLow: 1'b1, busy: 1'b1, req: 1'b0},
    '{off: 8'(S_CYC + 1),              ras: 1'b0, casLow: 1'b1, busy: 1'b1, req: 1'b0},
    '{off: 8'(S_CYC + RL_CYC),         ras: 1'b0, casLow: 1'b1, busy: 1'b1, req: 1'b0},
    '{off: 8'(S_CYC + RL_CYC + 1),     ras: 1'b1, casLow: 1'b0, busy: 1'b1, req: 1'b0},
    '{off: 8'(L_CYC),                  ras: 1'b1, casLow: 1'b0, busy: 1'b1, req: 1'b0},
    '{off: 8'(L_CYC + 1),              ras: 1'b1, casLow: 1'b0, busy: 1'b0, req: 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       refGrant = 1'b0;
  logic       refReq, refBusy, initDone, refErr, rasN, weN;
  logic [1:0] casN;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dram_refresh_seq u_dram_refresh_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .refGrant (refGrant),
    .refReq   (refReq),
    .refBusy  (refBusy),
    .initDone (initDone),
    .refErr   (refErr),
    .rasN     (rasN),
    .casN     (casN),
    .weN      (weN)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // count RAS falls until initDone is seen high; returns count and cycle
  task automatic count_wake(output int falls, output int seenAt);
    logic prevRas;
    falls = 0;
    prevRas = rasN;
    while (!initDone) begin
      @(negedge clk);
      if (prevRas && !rasN) falls++;
      prevRas = rasN;
    end
    seenAt = cyc;
  endtask

  initial begin
    #(200000 * 8);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int c0, cInit, cInit2, cOv, falls, t0;
    bit casEarly;
    logic prevRas;

    repeat (3) @(negedge clk);
    // R1: reset state
    check(rasN == 1'b1, "R1 rasN", rasN, 1);
    check(casN == 2'b11, "R1 casN", casN, 3);
    check(weN == 1'b1 && refBusy == 1'b1, "R1 weN/busy", {weN, refBusy}, 3);
    check(initDone == 1'b0 && refReq == 1'b0, "R1 ready/req", {initDone, refReq}, 0);
    check(refErr == 1'b0, "R1 err", refErr, 0);

    // R11: grant held during pause; R2/R12: pause length
    refGrant = 1'b1;
    rst_n = 1'b1;
    c0 = cyc;
    casEarly = 1'b0;
    do begin
      @(negedge clk);
      if (casN != 2'b11 && (cyc - c0) < P_CYC) casEarly = 1'b1;
      if ((cyc - c0) == P_CYC)
        check(casN == 2'b00 && rasN == 1'b1, "R4 cas before ras", {casN, rasN}, 1);
    end while (rasN == 1'b1);
    check((cyc - c0) == P_CYC + S_CYC, "R2 R12 first ras fall", cyc - c0, P_CYC + S_CYC);
    check(!casEarly, "R11 grant ignored in pause", casEarly, 0);
    check(refBusy && !initDone, "R1 busy during wake", {refBusy, initDone}, 2);

    // R3: wake-up burst (first fall already seen)
    count_wake(falls, cInit);
    refGrant = 1'b0;
    check(falls + 1 == W_CYC, "R3 wake cycles", falls + 1, W_CYC);
    check((cInit - c0) == P_CYC + W_CYC * L_CYC, "R3 ready time", cInit - c0, P_CYC + W_CYC * L_CYC);

    // R7: first request after one interval
    while (cyc < cInit + RF_CYC - 1) @(negedge clk);
    check(refReq == 1'b0, "R7 no req before interval", refReq, 0);
    @(negedge clk);
    check(refReq == 1'b1, "R7 req at interval", refReq, 1);

    // R4 R5 R6 R8: single grant, profile table walked by one loop
    refGrant = 1'b1;
    @(negedge clk);
    refGrant = 1'b0;
    for (int off = 1; off <= L_CYC + 1; off++) begin
      for (int v = 0; v < NVEC; v++) begin
        if (int'(VECS[v].off) == off) begin
          check(rasN == VECS[v].ras && (casN == 2'b00) == VECS[v].casLow &&
                refBusy == VECS[v].busy && refReq == VECS[v].req && weN == 1'b1,
                "R4 R5 R6 R8 cycle profile",
                {rasN, casN, refBusy, refReq},
                {VECS[v].ras, {2{~VECS[v].casLow}}, VECS[v].busy, VECS[v].req});
        end
      end
      if (off < L_CYC + 1) @(negedge clk);
    end

    // R11: grant with nothing owed
    refGrant = 1'b1;
    casEarly = 1'b0;
    repeat (20) begin
      @(negedge clk);
      if (casN != 2'b11 || rasN != 1'b1) casEarly = 1'b1;
    end
    refGrant = 1'b0;
    check(!casEarly, "R11 grant ignored with nothing owed", casEarly, 0);

    // R9: three owed refreshes drained by a held grant
    while (cyc < cInit + 4 * RF_CYC + 2) @(negedge clk);
    check(refReq == 1'b1, "R9 req with backlog", refReq, 1);
    refGrant = 1'b1;
    falls = 0;
    prevRas = rasN;
    t0 = cyc;
    do begin
      @(negedge clk);
      if (prevRas && !rasN) falls++;
      prevRas = rasN;
    end while ((refReq || refBusy) && (cyc - t0) < 200);
    refGrant = 1'b0;
    check(falls == 3, "R9 drained count", falls, 3);
    check(refReq == 1'b0 && refBusy == 1'b0, "R9 idle after drain", {refReq, refBusy}, 0);

    // R10: withheld grants overflow the backlog
    while (!refErr) @(negedge clk);
    cOv = cyc;
    check(cOv == cInit + 9 * RF_CYC, "R10 overflow time", cOv - cInit, 9 * RF_CYC);
    check(initDone == 1'b0, "R10 ready withdrawn", initDone, 0);
    count_wake(falls, cInit2);
    check(falls == W_CYC, "R10 wake rerun", falls, W_CYC);
    check(refErr == 1'b1, "R10 error sticky", refErr, 1);
    while (cyc < cInit2 + RF_CYC - 1) @(negedge clk);
    check(refReq == 1'b0, "R10 backlog cleared", refReq, 0);
    @(negedge clk);
    check(refReq == 1'b1, "R7 R10 req after rewake", refReq, 1);

    finish_run();
  end

endmodule